// File: doc/BRIEF.md
# Register-mapped SPI master

This block is an SPI master peripheral controlled through three 32-bit registers: a combined control/status word, a data port and a clock divider. Software picks a chip-select line, the clock polarity and the phase, and the polarity of each chip-select line. It then writes bytes into a 16-entry transmit queue and sets the enable bit. While enable is set, the block shifts one byte at a time, MSB first, on `sclk`/`mosi` and captures one byte from `miso` for every byte it sends. Captured bytes go into a 16-entry receive queue, which software drains through the same data port.

Completion is a status condition, not an event. It reads true whenever the block is enabled, the transmit queue is empty and no byte is in flight, so it is already true at the moment the block is enabled with nothing queued. An interrupt line combines completion with a "receive queue needs draining" condition under two enable bits. When the receive queue is full, shifting pauses between bytes until software reads a byte.

Top module: `spi_regmaster`

## Requirements
- R1: After reset the control word reads 0x0004_0000 (only "transmit has room", bit 18, set), the divider reads 0, `irq` is 0, `sclk` is 0 and every `cs_o` line is high.
- R2: Byte offset 0x00 is control/status, 0x04 is the data port and 0x08 is the divider. The divider reads back the 16 bits written. Any other offset reads 0. Read data appears on `reg_rdata` one clock after the request.
- R3: Writing 1 to control bit 4 empties the transmit queue, and writing 1 to bit 5 empties the receive queue. Both bits always read 0.
- R4: Bit 16 (done) reads 1 exactly when enable (bit 7) is 1, the transmit queue is empty and no byte is being shifted. Enabling with an empty queue makes it read 1 at once.
- R5: Bit 17 = receive queue not empty, bit 18 = transmit queue not full, bit 19 = receive queue holds 12 or more bytes, bit 20 = receive queue full.
- R6: Each byte goes out MSB first, and one byte is captured per byte sent. Bit 3 sets the idle level of `sclk` (CPOL). With bit 2 (CPHA) at 0, data is sampled on the first edge of each bit. With CPHA at 1, data is sampled on the second edge. All four modes work.
- R7: The `sclk` period is D core cycles, where D is the divider with bit 0 cleared. A value of 0 or 1 means D = 65536. The first edge of a byte comes D/2 cycles after the byte is loaded.
- R8: Bits 1:0 select line 0, 1 or 2; the value 3 selects none. The selected line is at its active level while enable is set, and every line is at its idle level one cycle after enable clears. Line i is active-high when bit 6 or bit 21+i is 1, and active-low otherwise.
- R9: With the receive queue full, no new byte starts and `sclk` stays still. Reading one byte lets shifting resume.
- R10: `irq` is registered and equals (bit 9 AND done) OR (bit 10 AND bit 19) from the previous cycle.
- R11: A data-port write to a full transmit queue is dropped. A data-port read of an empty receive queue returns 0 and changes nothing.
- R12: Clearing enable in the middle of a byte aborts it: `sclk` returns to its idle level and the chip select is released on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | NCS | Chip-select lines, polarity programmable |
| irq | output | 1 | Level interrupt |

## Verification
The bench acts as an SPI slave that follows the selected mode on its own, and it sweeps all four modes with two dividers and rotating line and polarity choices. A swapped phase would show up as shifted received bytes, and a wrong polarity bit would drive the wrong line level. It measures the `sclk` period at divider values 8 and 3, and the first-edge delay at divider 0; a divider that did not ignore bit 0 or did not map 0 to the slowest rate would show the wrong cycle count. It fills the receive queue to check the stall and its release, and overfills the transmit queue to check that the extra byte is dropped. Finally it aborts a byte mid-flight in mode 3 to check that `sclk` idles high and the chip select is released at once.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_DATA = 4;
  localparam int OFS_DIV  = 8;

  localparam int B_SEL      = 0;
  localparam int B_CPHA     = 2;
  localparam int B_CPOL     = 3;
  localparam int B_FLUSH_TX = 4;
  localparam int B_FLUSH_RX = 5;
  localparam int B_POL_ALL  = 6;
  localparam int B_ACT      = 7;
  localparam int B_IE_DONE  = 9;
  localparam int B_IE_RXR   = 10;
  localparam int B_DONE     = 16;
  localparam int B_RXD      = 17;
  localparam int B_TXD      = 18;
  localparam int B_RXR      = 19;
  localparam int B_RXF      = 20;
  localparam int B_POL_LINE = 21;

  // bits that are stored in the control word
  localparam logic [31:0] CFG_MASK = 32'h00E0_06CF;
endpackage

// File: rtl/spi_rm_fifo.sv
module spi_rm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
      count <= count + CW'(push && !full) - CW'(pop && !empty);
    end
  end
endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine #(
  parameter int DW    = 8,
  parameter int DIV_W = 16,
  localparam int EW   = $clog2(2 * DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div,
  input  logic             tx_avail,
  input  logic [DW-1:0]    tx_byte,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [DW-1:0]    rx_byte,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  logic [DIV_W-1:0] half, hcnt;
  logic [EW-1:0]    ecnt;
  logic [DW-1:0]    txsh, rxsh;
  logic             tick, out_edge;

  // half period in core cycles; bit 0 ignored, zero maps to the slowest rate
  assign half     = (div[DIV_W-1:1] == '0) ? (DIV_W'(1) << (DIV_W - 1))
                                           : {1'b0, div[DIV_W-1:1]};
  assign tick     = busy && (hcnt == '0);
  assign out_edge = ecnt[0] ^ cpha;
  assign tx_pop   = active && !busy && tx_avail;
  assign rx_push  = tick && (ecnt == EW'(2 * DW - 1));
  assign rx_byte  = cpha ? {rxsh[DW-2:0], miso} : rxsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      hcnt <= '0;
      ecnt <= '0;
      txsh <= '0;
      rxsh <= '0;
    end else if (!active) begin
      busy <= 1'b0;
      sclk <= cpol;
      mosi <= 1'b0;
    end else if (!busy) begin
      sclk <= cpol;
      if (tx_pop) begin
        busy <= 1'b1;
        ecnt <= '0;
        hcnt <= half - 1'b1;
        if (cpha) begin
          txsh <= tx_byte;
        end else begin
          mosi <= tx_byte[DW-1];
          txsh <= {tx_byte[DW-2:0], 1'b0};
        end
      end
    end else if (!tick) begin
      hcnt <= hcnt - 1'b1;
    end else begin
      sclk <= ~sclk;
      hcnt <= half - 1'b1;
      ecnt <= ecnt + 1'b1;
      if (out_edge) begin
        mosi <= txsh[DW-1];
        txsh <= {txsh[DW-2:0], 1'b0};
      end else begin
        rxsh <= {rxsh[DW-2:0], miso};
      end
      if (rx_push) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_rm_csel.sv
module spi_rm_csel #(
  parameter int NCS = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           active,
  input  logic [1:0]     sel,
  input  logic           pol_all,
  input  logic [NCS-1:0] pol_line,
  output logic [NCS-1:0] cs_o
);
  for (genvar i = 0; i < NCS; i++) begin : g_line
    logic lvl;
    assign lvl = pol_all | pol_line[i];
    always_ff @(posedge clk) begin
      if (rst) cs_o[i] <= 1'b1;
      else     cs_o[i] <= (active && (sel == 2'(i))) ? lvl : ~lvl;
    end
  end
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_rm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int NCS    = 3,
  parameter int DIV_W  = 16,
  localparam int CW    = $clog2(DEPTH) + 1,
  localparam int RXR_LVL = (DEPTH * 3) / 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_o,
  output logic              irq
);
  logic [31:0]      cfg_q, status;
  logic [DIV_W-1:0] div_q;
  logic             hit_ctrl, hit_data, hit_div, wr_ctrl;
  logic             flush_tx, flush_rx, tx_push, rx_pop;
  logic [DW-1:0]    tx_head, rx_head, rx_byte;
  logic [CW-1:0]    tx_count, rx_count;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic             tx_pop, rx_push, eng_busy, done, rxr;

  assign hit_ctrl = reg_en && (reg_addr == ADDR_W'(OFS_CTRL));
  assign hit_data = reg_en && (reg_addr == ADDR_W'(OFS_DATA));
  assign hit_div  = reg_en && (reg_addr == ADDR_W'(OFS_DIV));
  assign wr_ctrl  = hit_ctrl && reg_we;
  assign flush_tx = wr_ctrl && reg_wdata[B_FLUSH_TX];
  assign flush_rx = wr_ctrl && reg_wdata[B_FLUSH_RX];
  assign tx_push  = hit_data && reg_we;
  assign rx_pop   = hit_data && !reg_we;

  assign done = cfg_q[B_ACT] && tx_empty && !eng_busy;
  assign rxr  = (rx_count >= CW'(RXR_LVL));

  always_comb begin
    status         = cfg_q;
    status[B_DONE] = done;
    status[B_RXD]  = !rx_empty;
    status[B_TXD]  = !tx_full;
    status[B_RXR]  = rxr;
    status[B_RXF]  = rx_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      div_q     <= '0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr_ctrl)          cfg_q <= reg_wdata & CFG_MASK;
      if (hit_div && reg_we) div_q <= reg_wdata[DIV_W-1:0];
      if (reg_en && !reg_we) begin
        if (hit_ctrl)      reg_rdata <= status;
        else if (hit_data) reg_rdata <= rx_empty ? '0 : 32'(rx_head);
        else if (hit_div)  reg_rdata <= 32'(div_q);
        else               reg_rdata <= '0;
      end
      irq <= (cfg_q[B_IE_DONE] && done) || (cfg_q[B_IE_RXR] && rxr);
    end
  end

  spi_rm_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(flush_tx), .push(tx_push), .wdata(reg_wdata[DW-1:0]),
    .pop(tx_pop), .rdata(tx_head), .count(tx_count), .empty(tx_empty), .full(tx_full)
  );

  spi_rm_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(flush_rx), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head), .count(rx_count), .empty(rx_empty), .full(rx_full)
  );

  spi_rm_engine #(.DW(DW), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .active(cfg_q[B_ACT]), .cpol(cfg_q[B_CPOL]), .cpha(cfg_q[B_CPHA]),
    .div(div_q), .tx_avail(!tx_empty && !rx_full), .tx_byte(tx_head), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .busy(eng_busy), .sclk(sclk), .mosi(mosi),
    .miso(miso)
  );

  spi_rm_csel #(.NCS(NCS)) u_cs (
    .clk(clk), .rst(rst), .active(cfg_q[B_ACT]), .sel(cfg_q[B_SEL +: 2]),
    .pol_all(cfg_q[B_POL_ALL]), .pol_line(cfg_q[B_POL_LINE +: NCS]), .cs_o(cs_o)
  );
endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk #(
  parameter int NCS   = 3,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic           clk,
  input logic           rst,
  input logic [31:0]    cfg_q,
  input logic           sclk,
  input logic [NCS-1:0] cs_o,
  input logic           irq,
  input logic           flush_tx,
  input logic [CW-1:0]  tx_count,
  input logic           rx_full,
  input logic           rx_push
);
  logic [NCS-1:0] idle_lvl;
  always_comb begin
    for (int i = 0; i < NCS; i++) idle_lvl[i] = ~(cfg_q[6] | cfg_q[21 + i]);
  end

  p_sclk_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[7] |=> sclk == $past(cfg_q[3]));

  p_cs_release_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[7] |=> cs_o == $past(idle_lvl));

  p_flush_tx_r3: assert property (@(posedge clk) disable iff (rst)
    flush_tx |=> tx_count == '0);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    rx_full |-> !rx_push);

  p_tx_bound_r11: assert property (@(posedge clk) disable iff (rst)
    tx_count <= CW'(DEPTH));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q[9] && !cfg_q[10]) |=> !irq);
endmodule

bind spi_regmaster spi_regmaster_chk #(.NCS(NCS), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_q(cfg_q), .sclk(sclk), .cs_o(cs_o), .irq(irq),
  .flush_tx(flush_tx), .tx_count(tx_count), .rx_full(rx_full), .rx_push(rx_push)
);

// File: tb/spi_regmaster_tb.sv
module spi_regmaster_tb;
  localparam logic [4:0] A_CTRL = 5'h00, A_DATA = 5'h04, A_DIV = 5'h08;

  logic clk = 0, rst = 1;
  logic reg_en = 0, reg_we = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, mosi, miso = 0, irq;
  logic [2:0] cs_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  // slave model state
  logic s_cpol = 0, s_cpha = 0, s_lvl = 0;
  int   s_sel = 0;
  int   so_idx = 0, sr_cnt = 0, oi = 0, ii = 0;
  logic [7:0] sin = 0;
  logic [7:0] sr [256];
  logic sclk_prev = 0;

  always #5 clk = ~clk;

  spi_regmaster u_dut (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_o(cs_o), .irq(irq)
  );

  function automatic logic [7:0] pat(int k);
    return 8'(k * 29 + 90);
  endfunction

  function automatic logic [7:0] txv(int k);
    return 8'(k * 53 + 17);
  endfunction

  function automatic logic [31:0] mk(int mode, int sel, bit gp, bit lp, bit act, bit ied, bit ier);
    logic [31:0] v;
    v = 32'(sel) | (32'(mode & 1) << 2) | (32'((mode >> 1) & 1) << 3);
    v = v | (32'(gp) << 6) | (32'(act) << 7) | (32'(ied) << 9) | (32'(ier) << 10);
    if (sel < 3) v = v | (32'(lp) << (21 + sel));
    return v;
  endfunction

  // SPI slave: shifts pat(so_idx) out, records what it samples
  always @(negedge clk) begin
    logic act, lead;
    act = (s_sel < 3) && (cs_o[s_sel[1:0]] == s_lvl);
    if (!act) begin
      oi = 0; ii = 0;
      if (!s_cpha) miso = pat(so_idx)[7];
    end else if (sclk != sclk_prev) begin
      lead = (sclk != s_cpol);
      if (lead ^ s_cpha) begin
        sin = {sin[6:0], mosi};
        ii++;
        if (ii == 8) begin sr[sr_cnt % 256] = sin; sr_cnt++; ii = 0; end
      end else if (s_cpha) begin
        miso = pat(so_idx)[7 - oi];
        oi++;
        if (oi == 8) begin oi = 0; so_idx++; end
      end else begin
        oi++;
        if (oi == 8) begin oi = 0; so_idx++; end
        miso = pat(so_idx)[7 - oi];
      end
    end
    sclk_prev = sclk;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); reg_en = 0; d = reg_rdata;
  endtask

  task automatic wait_done(output logic [31:0] d);
    int t = 0;
    do begin rd(A_CTRL, d); t++; end while (!d[16] && t < 5000);
  endtask

  task automatic rise_gap(output int gap);
    int n = 0; logic p;
    @(negedge clk); p = sclk;
    while (n < 100000) begin @(negedge clk); n++; if (!p && sclk) break; p = sclk; end
    n = 0; p = sclk;
    while (n < 100000) begin @(negedge clk); n++; if (!p && sclk) break; p = sclk; end
    gap = n;
  endtask

  task automatic run_xfer(int mode, int dv, int sel, bit gp, bit lp, int n);
    logic [31:0] d; logic [2:0] idle; int ob, ib;
    s_cpha = mode[0]; s_cpol = mode[1]; s_sel = sel; s_lvl = gp | lp;
    wr(A_DIV, 32'(dv));
    wr(A_CTRL, mk(mode, sel, gp, lp, 0, 0, 0) | 32'h30);
    ob = so_idx; ib = sr_cnt;
    for (int i = 0; i < n; i++) wr(A_DATA, 32'(txv(ib + i)));
    wr(A_CTRL, mk(mode, sel, gp, lp, 1, 0, 0));
    @(negedge clk);
    chk("R8 active level", 32'(cs_o[sel]), 32'(gp | lp));
    wait_done(d);
    chk("R4 done after transfer", 32'(d[16]), 1);
    wr(A_CTRL, mk(mode, sel, gp, lp, 0, 0, 0));
    @(negedge clk);
    for (int i = 0; i < 3; i++) idle[i] = ~(gp | (lp && i == sel));
    chk("R8 released", 32'(cs_o), 32'(idle));
    for (int i = 0; i < n; i++) begin
      rd(A_DATA, d);
      chk("R6 rx byte", d, 32'(pat(ob + i)));
      chk("R6 tx byte", 32'(sr[(ib + i) % 256]), 32'(txv(ib + i)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; int g, ob, ib;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0004_0000);
    rd(A_DIV, d);  chk("R1 div", d, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 cs", 32'(cs_o), 32'h7);
    chk("R1 sclk", 32'(sclk), 0);
    // R2 decode
    wr(A_DIV, 32'hFFFF_1235); rd(A_DIV, d); chk("R2 div readback", d, 32'h1235);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, d); chk("R2 unmapped", d, 0);
    rd(5'h14, d); chk("R2 unmapped", d, 0);
    // R4 / R10 done on empty enable
    wr(A_CTRL, mk(0, 0, 0, 0, 1, 1, 0));
    rd(A_CTRL, d);
    chk("R4 done immediate", 32'(d[16]), 1);
    chk("R10 irq on done", 32'(irq), 1);
    wr(A_CTRL, mk(0, 0, 0, 0, 1, 0, 0));
    rd(A_CTRL, d);
    chk("R10 irq masked", 32'(irq), 0);
    wr(A_CTRL, 0);
    rd(A_CTRL, d); chk("R4 done needs enable", 32'(d[16]), 0);
    // R6 / R8 sweep
    for (int m = 0; m < 4; m++)
      for (int v = 0; v < 2; v++)
        run_xfer(m, 2 << v, (m + v) % 3, m == 1, m == 2, 5);
    // R8 select 3 drives nothing
    wr(A_CTRL, mk(0, 3, 0, 0, 1, 0, 0));
    @(negedge clk); chk("R8 no line", 32'(cs_o), 32'h7);
    wr(A_CTRL, 0);
    // R7 period
    s_sel = 0; s_cpol = 0; s_cpha = 0; s_lvl = 0;
    wr(A_DIV, 8); wr(A_DATA, 8'hA5); wr(A_CTRL, mk(0, 0, 0, 0, 1, 0, 0));
    rise_gap(g); chk("R7 period div8", 32'(g), 8);
    wait_done(d); wr(A_CTRL, 32'h30);
    wr(A_DIV, 3); wr(A_DATA, 8'h3C); wr(A_CTRL, mk(0, 0, 0, 0, 1, 0, 0));
    rise_gap(g); chk("R7 period div3", 32'(g), 2);
    wait_done(d); wr(A_CTRL, 32'h30);
    wr(A_DIV, 0); wr(A_DATA, 8'h11); wr(A_CTRL, mk(0, 0, 0, 0, 1, 0, 0));
    g = 0;
    while (!sclk && g < 40000) begin @(negedge clk); g++; end
    chk("R7 divider zero first edge", 32'(g), 32769);
    wr(A_CTRL, 32'h30);
    // R9 / R5 stall on full receive queue
    wr(A_DIV, 2); wr(A_CTRL, 32'h30);
    ob = so_idx;
    for (int i = 0; i < 16; i++) wr(A_DATA, 32'(txv(i)));
    wr(A_CTRL, mk(0, 0, 0, 0, 1, 0, 0));
    wait_done(d);
    chk("R5 flags full", 32'(d[20:16]), 5'b11111);
    wr(A_DATA, 8'h77);
    g = 0;
    for (int i = 0; i < 100; i++) begin
      logic p; p = sclk; @(negedge clk); if (sclk != p) g++;
    end
    chk("R9 sclk still", 32'(g), 0);
    rd(A_CTRL, d); chk("R9 flags stalled", 32'(d[20:16]), 5'b11110);
    wr(A_CTRL, mk(0, 0, 0, 0, 1, 0, 1));
    rd(A_CTRL, d); chk("R10 irq on rx level", 32'(irq), 1);
    rd(A_DATA, d); chk("R9 first byte", d, 32'(pat(ob)));
    wait_done(d);
    chk("R9 resumed full", 32'(d[20]), 1);
    for (int i = 1; i <= 16; i++) begin
      rd(A_DATA, d); chk("R9 rx byte", d, 32'(pat(ob + i)));
    end
    rd(A_CTRL, d); chk("R5 flags drained", 32'(d[20:16]), 5'b00101);
    wr(A_CTRL, 0);
    // R11 / R3 overfill and flush
    ib = sr_cnt;
    for (int i = 0; i < 17; i++) wr(A_DATA, 32'(txv(100 + i)));
    rd(A_CTRL, d); chk("R11 tx full flag", 32'(d[18]), 0);
    wr(A_CTRL, mk(0, 0, 0, 0, 1, 0, 0));
    wait_done(d);
    chk("R11 extra dropped", 32'(sr_cnt - ib), 16);
    chk("R11 last byte", 32'(sr[(ib + 15) % 256]), 32'(txv(115)));
    wr(A_CTRL, 32'h20);
    rd(A_CTRL, d);
    chk("R3 rx flushed", 32'(d[17]), 0);
    chk("R3 flush bits read 0", 32'(d[5:4]), 0);
    rd(A_DATA, d); chk("R11 empty read", d, 0);
    for (int i = 0; i < 3; i++) wr(A_DATA, 8'h55);
    wr(A_CTRL, 32'h10);
    rd(A_CTRL, d); chk("R3 tx flushed", 32'(d[18]), 1);
    wr(A_CTRL, mk(0, 0, 0, 0, 1, 0, 0));
    rd(A_CTRL, d); chk("R3 tx empty so done", 32'(d[16]), 1);
    wr(A_CTRL, 0);
    // R12 abort mid byte, mode 3
    s_cpol = 1; s_cpha = 1;
    wr(A_DIV, 64); wr(A_CTRL, mk(3, 1, 0, 0, 0, 0, 0) | 32'h30);
    wr(A_DATA, 8'hC3);
    wr(A_CTRL, mk(3, 1, 0, 0, 1, 0, 0));
    repeat (100) @(negedge clk);
    wr(A_CTRL, mk(3, 1, 0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R12 sclk idle", 32'(sclk), 1);
    chk("R12 cs released", 32'(cs_o), 32'h7);
    rd(A_CTRL, d); chk("R12 nothing received", 32'(d[17]), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule